// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

The block counts cycles of an oscillator-rate enable and emits a one-cycle tick at the end of every second. A three-bit trim code, held in a small host-writable register, corrects the average tick rate by a signed amount in parts per million. The correction works by shortening or lengthening individual seconds by whole oscillator counts. It does not apply a fractional change to every second.

A fractional residue accumulator makes this correction. At every seconds boundary it adds the trimmed error for one second, expressed in units of 1/`PPM_SCALE` of a count. Each whole count that overflows is taken out of the following second, or added to it, and the remainder is carried forward. Over many seconds the average period therefore tracks `NOMINAL_COUNT * (1 - ppm/PPM_SCALE)`. By default the nominal rate is 32768 counts per second and one trim step is 20 ppm.

Top module: `trim_sec_prescaler`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the trim register to 000, clears the residue and the count, and holds `sec_tick` low. The first second after reset lasts exactly `NOMINAL_COUNT` enabled cycles.
- R2: `sec_tick` is high for exactly one clock cycle. It rises in the cycle after the clock edge that consumes the last enabled count of a second.
- R3: Only cycles with `osc_en` high advance the count. Cycles with `osc_en` low change neither the count nor the residue.
- R4: Trim code bit 2 is the sign: 0 shortens seconds (positive correction) and 1 lengthens them. Bit 1 weighs two steps and bit 0 weighs one step, so the magnitude is `trim[1:0] * STEP_PPM` ppm. The range is -60 to +60 ppm with default parameters.
- R5: Codes 000 and 100 give zero correction. Every second then lasts exactly `NOMINAL_COUNT` enabled cycles, and the residue is left unchanged.
- R6: At each boundary, `trim[1:0]*STEP_PPM*NOMINAL_COUNT` is added to the residue. The integer part `k = sum / PPM_SCALE` sets the next second to `NOMINAL_COUNT - k` cycles (sign 0) or `NOMINAL_COUNT + k` cycles (sign 1). The residue becomes `sum mod PPM_SCALE`.
- R7: When `trim_we` is high at a clock edge, `trim_wdata` is stored and appears on `trim_q` after that edge. When `trim_we` is low, `trim_wdata` is ignored and `trim_q` holds its value.
- R8: A trim written in mid-second shapes only the second that starts at the next boundary. The residue is kept across any code change, including a sign change.
- R9: A reset asserted mid-run restores the state described in R1, whatever the previous trim and residue were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator-rate count enable |
| trim_we | input | 1 | Trim register write strobe |
| trim_wdata | input | 3 | Trim code to write: {sign, 2-step bit, 1-step bit} |
| trim_q | output | 3 | Current trim register contents |
| sec_tick | output | 1 | One-cycle seconds tick |

## Verification
The hardest state to reach is a residue that sits just below one whole count when the trim code changes. That case shows that the residue survives a sign flip and can push two or three count corrections into a single second. The bench runs the bench parameters at a small nominal count and a coarse scale, so overflows occur every second or two. It holds large trim codes for several seconds, then flips the sign and drops to zero mid-second, and finally mixes in random enable gaps and random writes. The bench recomputes the residue independently and checks the length of every second.

// File: rtl/sp_pkg.sv
package sp_pkg;

   typedef struct packed {
      logic       neg;
      logic [1:0] steps;
   } trim_dec_t;

   function automatic int max_adjust(input int nominal, input int step_ppm, input int scale);
      int max_add;
      max_add = 3 * step_ppm * nominal;
      return (scale - 1 + max_add) / scale;
   endfunction

endpackage

// File: rtl/sp_trim_decode.sv
module sp_trim_decode
   import sp_pkg::*;
(
   input  logic [2:0] code,
   output trim_dec_t  dec
);
   always_comb begin
      dec.steps = code[1:0];
      dec.neg   = code[2] & (code[1:0] != 2'd0);
   end
endmodule

// File: rtl/sp_frac_accum.sv
module sp_frac_accum #(
   parameter int NOMINAL_COUNT = 32768,
   parameter int STEP_PPM      = 20,
   parameter int PPM_SCALE     = 1000000,
   parameter int MAX_ADJ       = 2,
   parameter int ADJ_W         = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             boundary,
   input  logic [1:0]       steps,
   output logic [ADJ_W-1:0] adj
);
   localparam int MAX_ADD = 3 * STEP_PPM * NOMINAL_COUNT;
   localparam int ACC_W   = $clog2(PPM_SCALE + MAX_ADD + 1);
   localparam logic [ACC_W-1:0] STEP_ADD = ACC_W'(STEP_PPM * NOMINAL_COUNT);
   localparam logic [ACC_W-1:0] SCALE_V  = ACC_W'(PPM_SCALE);

   logic [ACC_W-1:0]   residue;
   logic [ACC_W-1:0]   sum;
   logic [ACC_W-1:0]   residue_nx;
   logic [MAX_ADJ-1:0] over;

   assign sum = residue + ACC_W'(steps) * STEP_ADD;

   for (genvar k = 1; k <= MAX_ADJ; k++) begin : g_thr
      assign over[k-1] = (sum >= ACC_W'(k * PPM_SCALE));
   end

   always_comb begin
      adj        = ADJ_W'($countones(over));
      residue_nx = sum - ACC_W'(adj) * SCALE_V;
   end

   always_ff @(posedge clk) begin
      if (rst)           residue <= '0;
      else if (boundary) residue <= residue_nx;
   end

   p_residue_bound_r6: assert property (@(posedge clk) disable iff (rst)
      residue < SCALE_V);
   p_zero_keeps_r5: assert property (@(posedge clk) disable iff (rst)
      (boundary && steps == 2'd0) |=> $stable(residue));
   p_idle_keeps_r3: assert property (@(posedge clk) disable iff (rst)
      !boundary |=> $stable(residue));
endmodule

// File: rtl/sp_sec_counter.sv
module sp_sec_counter #(
   parameter int NOMINAL_COUNT = 32768,
   parameter int MAX_ADJ       = 2,
   parameter int CNT_W         = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic [CNT_W-1:0] next_len_m1,
   output logic             boundary,
   output logic [CNT_W-1:0] period_m1,
   output logic             sec_tick
);
   localparam logic [CNT_W-1:0] NOM_M1 = CNT_W'(NOMINAL_COUNT - 1);

   logic [CNT_W-1:0] cnt;

   assign boundary = tick_en && (cnt == period_m1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt       <= '0;
         period_m1 <= NOM_M1;
         sec_tick  <= 1'b0;
      end else begin
         sec_tick <= boundary;
         if (boundary) begin
            cnt       <= '0;
            period_m1 <= next_len_m1;
         end else if (tick_en) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
      cnt <= period_m1);
   p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
      sec_tick |=> !sec_tick);
   p_tick_follows_r2: assert property (@(posedge clk) disable iff (rst)
      boundary |=> sec_tick);
   p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
      !tick_en |=> $stable(cnt));
endmodule

// File: rtl/trim_sec_prescaler.sv
module trim_sec_prescaler
   import sp_pkg::*;
#(
   parameter int NOMINAL_COUNT = 32768,
   parameter int STEP_PPM      = 20,
   parameter int PPM_SCALE     = 1000000
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       osc_en,
   input  logic       trim_we,
   input  logic [2:0] trim_wdata,
   output logic [2:0] trim_q,
   output logic       sec_tick
);
   localparam int MAX_ADJ = max_adjust(NOMINAL_COUNT, STEP_PPM, PPM_SCALE);
   localparam int ADJ_W   = $clog2(MAX_ADJ + 1);
   localparam int CNT_W   = $clog2(NOMINAL_COUNT + MAX_ADJ + 1);
   localparam logic [CNT_W-1:0] NOM_M1 = CNT_W'(NOMINAL_COUNT - 1);

   if (MAX_ADJ < 1) begin : g_bad_adj
      $error("trim step too small to ever move a count");
   end
   if (NOMINAL_COUNT <= 2 * MAX_ADJ + 2) begin : g_bad_nom
      $error("nominal count too small for trim range");
   end
   if (PPM_SCALE < 1) begin : g_bad_scale
      $error("ppm scale must be positive");
   end

   trim_dec_t        dec;
   logic [ADJ_W-1:0] adj;
   logic             boundary;
   logic [CNT_W-1:0] next_len_m1;
   logic [CNT_W-1:0] period_m1;

   always_ff @(posedge clk) begin
      if (rst)          trim_q <= 3'b000;
      else if (trim_we) trim_q <= trim_wdata;
   end

   sp_trim_decode u_dec (
      .code (trim_q),
      .dec  (dec)
   );

   sp_frac_accum #(
      .NOMINAL_COUNT (NOMINAL_COUNT),
      .STEP_PPM      (STEP_PPM),
      .PPM_SCALE     (PPM_SCALE),
      .MAX_ADJ       (MAX_ADJ),
      .ADJ_W         (ADJ_W)
   ) u_acc (
      .clk      (clk),
      .rst      (rst),
      .boundary (boundary),
      .steps    (dec.steps),
      .adj      (adj)
   );

   assign next_len_m1 = dec.neg ? NOM_M1 + CNT_W'(adj) : NOM_M1 - CNT_W'(adj);

   sp_sec_counter #(
      .NOMINAL_COUNT (NOMINAL_COUNT),
      .MAX_ADJ       (MAX_ADJ),
      .CNT_W         (CNT_W)
   ) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .tick_en     (osc_en),
      .next_len_m1 (next_len_m1),
      .boundary    (boundary),
      .period_m1   (period_m1),
      .sec_tick    (sec_tick)
   );

   p_shorten_r4: assert property (@(posedge clk) disable iff (rst)
      (boundary && !trim_q[2]) |=> period_m1 <= NOM_M1);
   p_lengthen_r4: assert property (@(posedge clk) disable iff (rst)
      (boundary && trim_q[2]) |=> period_m1 >= NOM_M1);
   p_zero_nominal_r5: assert property (@(posedge clk) disable iff (rst)
      (boundary && trim_q[1:0] == 2'd0) |=> period_m1 == NOM_M1);
   p_write_r7: assert property (@(posedge clk) disable iff (rst)
      trim_we |=> trim_q == $past(trim_wdata));
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !trim_we |=> $stable(trim_q));
endmodule

// File: tb/tb_trim_sec_prescaler.sv
module tb_trim_sec_prescaler;
   localparam int CLK_PERIOD = 10;
   localparam int NOM        = 40;
   localparam int STEP       = 20;
   localparam int SCALE      = 1000;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       osc_en = 1'b0;
   logic       trim_we = 1'b0;
   logic [2:0] trim_wdata = 3'b000;
   logic [2:0] trim_q;
   logic       sec_tick;

   int checks = 0;
   int errors = 0;
   int residue = 0;
   int exp_len = NOM;
   int en_count = 0;
   int model_trim = 0;
   int ticks_seen = 0;
   logic prev_tick = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trim_sec_prescaler #(
      .NOMINAL_COUNT (NOM),
      .STEP_PPM      (STEP),
      .PPM_SCALE     (SCALE)
   ) dut (
      .clk        (clk),
      .rst        (rst),
      .osc_en     (osc_en),
      .trim_we    (trim_we),
      .trim_wdata (trim_wdata),
      .trim_q     (trim_q),
      .sec_tick   (sec_tick)
   );

   function automatic int next_length(input int code, inout int res);
      int mag;
      int sum;
      int k;
      mag = (code & 3) * STEP * NOM;
      sum = res + mag;
      k   = sum / SCALE;
      res = sum % SCALE;
      return ((code >> 2) & 1) ? NOM + k : NOM - k;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic observe();
      en_count += int'(osc_en);
      if (sec_tick) begin
         check(!prev_tick, "R2 tick width", 1, 0);
         check(en_count == exp_len, "R3/R6 second length", en_count, exp_len);
         en_count = 0;
         ticks_seen++;
         exp_len = next_length(model_trim, residue);
      end
      prev_tick = sec_tick;
   endtask

   task automatic cyc(input bit e, input bit w, input logic [2:0] d);
      @(negedge clk);
      observe();
      osc_en     = e;
      trim_we    = w && !e;
      trim_wdata = d;
      if (w && !e) model_trim = int'(d);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; osc_en = 1'b0; trim_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      residue = 0; exp_len = NOM; en_count = 0; model_trim = 0; prev_tick = 1'b0;
      check(sec_tick == 1'b0, "R1 tick after reset", int'(sec_tick), 0);
      check(trim_q == 3'b000, "R1 trim after reset", int'(trim_q), 0);
   endtask

   task automatic write_trim(input logic [2:0] d);
      cyc(1'b0, 1'b1, d);
      cyc(1'b0, 1'b0, 3'b000);
      check(trim_q == d, "R7 trim write", int'(trim_q), int'(d));
   endtask

   task automatic run_seconds(input int n, input int en_pct);
      int target;
      target = ticks_seen + n;
      while (ticks_seen < target)
         cyc(($urandom % 100) < en_pct, 1'b0, 3'($urandom));
   endtask

   initial begin
      void'($urandom(32'd1357));
      do_reset();
      // R1 / R5: first seconds at nominal length
      run_seconds(3, 100);
      // R7: data ignored without strobe
      cyc(1'b0, 1'b0, 3'b111);
      cyc(1'b0, 1'b0, 3'b101);
      check(trim_q == 3'b000, "R7 ignore without we", int'(trim_q), 0);
      // R4 / R6: largest positive correction
      write_trim(3'b011);
      run_seconds(6, 100);
      // R8: flip sign mid-second, residue kept
      repeat (17) cyc(1'b1, 1'b0, 3'b000);
      write_trim(3'b111);
      run_seconds(6, 70);
      // R5: code 100 means zero correction
      write_trim(3'b100);
      run_seconds(4, 60);
      write_trim(3'b001);
      run_seconds(5, 100);
      write_trim(3'b110);
      run_seconds(5, 50);
      // R9: mid-run reset
      repeat (11) cyc(1'b1, 1'b0, 3'b000);
      do_reset();
      run_seconds(2, 100);
      // random mix of enables and writes
      for (int i = 0; i < 6000; i++) begin
         bit e;
         e = ($urandom % 100) < 60;
         if (!e && ($urandom % 50) == 0) cyc(1'b0, 1'b1, 3'($urandom));
         else cyc(e, 1'b0, 3'($urandom));
      end
      run_seconds(1, 100);
      check(ticks_seen > 60, "R2 tick count", ticks_seen, 61);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", ticks_seen, -1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule